// File: doc/BRIEF.md
# Strobe-Driven UART Word Formatter

This block turns the multiplexed digit scan of a dual-slope converter into a stream of byte-wide words for a UART transmitter. Every falling edge of the active-low strobe, after a two-flop synchroniser, produces one load pulse. The word loaded with it carries a digit tag in its high nibble and the digit's BCD value in its low nibble. A full reading is five words, sent from the most significant digit down to the least.

The most significant digit can only be 0 or 1, so its three upper BCD bits are always zero. In that word those bits carry the overrange, underrange and polarity flags. Polarity also drives the transmitter's even-parity select. That select is captured only when the most significant digit's word loads, so it stays fixed for the rest of the five-word stream. If a strobe arrives while the transmitter still reports busy, a sticky error flag is set and the newer word is loaded anyway.

When the command path is enabled, a command-ready level from the receive side issues a one-clock run request to the converter's run/hold input. A rising edge of the converter's busy line produces a one-clock pulse that clears the receiver's data-ready flag.

Top module: `strobe_word_fmt`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, `tx_load`, `tx_par_even`, `overrun`, `run_hold` and `rx_clr` are 0 and `tx_data` is 0.
- R2: Each high-to-low transition of `strobe_n` gives exactly one `tx_load` pulse, one clock wide, after the third rising clock edge that follows the transition. This holds however many clocks the strobe stays low.
- R3: In a loaded word, bits 7:4 are 0000 when `digit_sel[4]` (most significant digit) is set. They are 1000 for `digit_sel[3]`, 0100 for `digit_sel[2]`, 0010 for `digit_sel[1]` and 0001 for `digit_sel[0]`.
- R4: For digits other than the most significant, bits 3:0 of the loaded word equal `bcd` as sampled on the load edge.
- R5: For the most significant digit, bit 3 is `ovr_in`, bit 2 is `und_in`, bit 1 is `pol_in` and bit 0 is `bcd[0]`.
- R6: `tx_par_even` takes the value of `pol_in` only on a load of a most-significant-digit word. A change of `pol_in` during the other four words of a stream has no effect on it.
- R7: If `tx_busy` is high on the edge that loads a word, `overrun` goes high together with `tx_load` and stays high until reset. The word is still loaded.
- R8: `rx_clr` is high for exactly the one clock after an edge on which `adc_busy` is sampled high, where it was sampled low on the previous edge.
- R9: With `CMD_EN`=1, `run_hold` is high in the clock after an edge on which `rx_cmd` is high and `adc_busy` is low, and low otherwise. With `CMD_EN`=0, `run_hold` is always low.
- R10: `tx_data` keeps its value in every clock that is not a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_n | input | 1 | Active-low digit strobe, asynchronous |
| digit_sel | input | 5 | One-hot digit drive, bit 4 = most significant digit |
| bcd | input | 4 | BCD value of the current digit |
| pol_in | input | 1 | Reading polarity, 1 = positive |
| ovr_in | input | 1 | Overrange status |
| und_in | input | 1 | Underrange status |
| tx_busy | input | 1 | Transmitter still shifting the previous word |
| adc_busy | input | 1 | Converter busy (measurement in progress) |
| rx_cmd | input | 1 | Receiver holds a start command |
| tx_data | output | 8 | Word presented to the transmitter |
| tx_load | output | 1 | One-clock load pulse to the transmitter |
| tx_par_even | output | 1 | Even-parity select for the transmitter |
| overrun | output | 1 | Sticky: a word was loaded while the transmitter was busy |
| run_hold | output | 1 | One-clock run request to the converter |
| rx_clr | output | 1 | One-clock clear of the receiver's data-ready flag |

## Verification
Two functions can act in the same cycle. The first pair is the load of a word and the setting of the overrun flag. The bench makes its transmitter model stay busy longer than the strobe spacing, so a strobe lands on a busy transmitter. It then checks, on every clock, that the load pulse, the newer word and the raised flag appear together. The second pair is the parity capture and a polarity change: polarity is toggled right after the most significant digit loads, and the parity select must hold its captured value through the remaining four words.

// File: rtl/strobe_word_fmt.sv
module strobe_word_fmt #(
  parameter int NDIG   = 5,
  parameter int BCDW   = 4,
  parameter int SYNC   = 2,
  parameter int CMD_EN = 1,
  localparam int TAGW  = NDIG - 1,
  localparam int WW    = TAGW + BCDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_n,
  input  logic [NDIG-1:0] digit_sel,
  input  logic [BCDW-1:0] bcd,
  input  logic            pol_in,
  input  logic            ovr_in,
  input  logic            und_in,
  input  logic            tx_busy,
  input  logic            adc_busy,
  input  logic            rx_cmd,
  output logic [WW-1:0]   tx_data,
  output logic            tx_load,
  output logic            tx_par_even,
  output logic            overrun,
  output logic            run_hold,
  output logic            rx_clr
);

  logic [SYNC:0]   sh;
  logic            fire;
  logic            msd;
  logic [BCDW-1:0] nib;
  logic            busy_q;

  assign fire = sh[SYNC] & ~sh[SYNC-1];
  assign msd  = digit_sel[NDIG-1];

  always_comb begin
    nib = bcd;
    if (msd) nib[3:1] = {ovr_in, und_in, pol_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh          <= '1;
      tx_load     <= 1'b0;
      tx_data     <= '0;
      tx_par_even <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      sh      <= {sh[SYNC-1:0], strobe_n};
      tx_load <= fire;
      if (fire) begin
        tx_data <= {digit_sel[TAGW-1:0], nib};
        if (msd) tx_par_even <= pol_in;
        if (tx_busy) overrun <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rx_clr <= 1'b0;
    end else begin
      busy_q <= adc_busy;
      rx_clr <= adc_busy & ~busy_q;
    end
  end

  generate
    if (CMD_EN != 0) begin : g_cmd
      always_ff @(posedge clk) begin
        if (!rst_n) run_hold <= 1'b0;
        else        run_hold <= rx_cmd & ~adc_busy;
      end
    end else begin : g_nocmd
      assign run_hold = 1'b0;
    end
  endgenerate

endmodule

module strobe_word_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] tx_data,
  input logic       tx_load,
  input logic       tx_par_even,
  input logic       overrun,
  input logic       run_hold,
  input logic       rx_cmd,
  input logic       rx_clr
);
  AST_LOAD_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) tx_load |=> !tx_load); // R2
  AST_TAG_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) tx_load |-> $onehot0(tx_data[7:4])); // R3
  AST_PAR_AT_MSD:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(tx_par_even) |-> (tx_load && tx_data[7:4] == 4'b0000)); // R6
  AST_OVR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R7
  AST_OVR_WITH_LD:  assert property (@(posedge clk) disable iff (!rst_n) $rose(overrun) |-> tx_load); // R7
  AST_CLR_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) rx_clr |=> !rx_clr); // R8
  AST_RUN_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n) run_hold |-> $past(rx_cmd)); // R9
  AST_DATA_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !tx_load |-> $stable(tx_data)); // R10
endmodule

bind strobe_word_fmt strobe_word_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
  .tx_par_even(tx_par_even), .overrun(overrun), .run_hold(run_hold),
  .rx_cmd(rx_cmd), .rx_clr(rx_clr)
);

// File: tb/tb_strobe_word_fmt.sv
module tb_strobe_word_fmt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_n = 1'b1;
  logic [4:0] digit_sel = '0;
  logic [3:0] bcd = '0;
  logic pol_in = 1'b0, ovr_in = 1'b0, und_in = 1'b0;
  logic tx_busy = 1'b0, adc_busy = 1'b0, rx_cmd = 1'b0;
  logic [7:0] tx_data, tx_data_nc;
  logic tx_load, tx_par_even, overrun, run_hold, rx_clr;
  logic tx_load_nc, par_nc, ovr_nc, run_nc, clr_nc;

  int vectors = 0, fails = 0;
  int tx_len = 8;
  int tx_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strobe_word_fmt dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .digit_sel(digit_sel), .bcd(bcd),
    .pol_in(pol_in), .ovr_in(ovr_in), .und_in(und_in), .tx_busy(tx_busy),
    .adc_busy(adc_busy), .rx_cmd(rx_cmd), .tx_data(tx_data), .tx_load(tx_load),
    .tx_par_even(tx_par_even), .overrun(overrun), .run_hold(run_hold), .rx_clr(rx_clr));

  strobe_word_fmt #(.CMD_EN(0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .digit_sel(digit_sel), .bcd(bcd),
    .pol_in(pol_in), .ovr_in(ovr_in), .und_in(und_in), .tx_busy(tx_busy),
    .adc_busy(adc_busy), .rx_cmd(rx_cmd), .tx_data(tx_data_nc), .tx_load(tx_load_nc),
    .tx_par_even(par_nc), .overrun(ovr_nc), .run_hold(run_nc), .rx_clr(clr_nc));

  // reference model
  bit hist[$];
  bit e_load, e_par, e_ovr, e_run, e_clr, busy_prev;
  logic [7:0] e_data;

  function automatic logic [7:0] make_word();
    logic [7:0] w = '0;
    for (int i = 0; i < 5; i++)
      if (digit_sel[i]) begin
        if (i == 4) w = {4'b0000, ovr_in, und_in, pol_in, bcd[0]};
        else        w = (8'h80 >> (3 - i)) | {4'b0, bcd};
      end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{1, 1, 1, 1};
      e_load = 0; e_par = 0; e_ovr = 0; e_run = 0; e_clr = 0; busy_prev = 0;
      e_data = '0;
    end else begin
      bit fire;
      hist.push_front(strobe_n);
      fire = (hist[2] == 0) && (hist[3] == 1);
      void'(hist.pop_back());
      e_load = fire;
      if (fire) begin
        e_data = make_word();
        if (digit_sel[4]) e_par = pol_in;
        if (tx_busy) e_ovr = 1;
      end
      e_clr = adc_busy && !busy_prev;
      busy_prev = adc_busy;
      e_run = rx_cmd && !adc_busy;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // transmitter model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n && tx_load) tx_cnt = tx_len;
    else if (tx_cnt > 0) tx_cnt--;
    tx_busy = (tx_cnt > 0);
    if (!done) begin
      vectors++;
      cmp("R2 tx_load", tx_load, e_load);
      cmp("R3 R4 R5 R10 tx_data", tx_data, e_data);
      cmp("R6 tx_par_even", tx_par_even, e_par);
      cmp("R7 overrun", overrun, e_ovr);
      cmp("R8 rx_clr", rx_clr, e_clr);
      cmp("R9 run_hold", run_hold, e_run);
      cmp("R9 run_hold CMD_EN=0", run_nc, 0);
    end
  end

  task automatic stream(input logic [3:0] v4, v3, v2, v1, v0, input bit p, o, u,
                        input int lowc, input int gap, input bit flip);
    logic [3:0] vals [5];
    vals[4] = v4; vals[3] = v3; vals[2] = v2; vals[1] = v1; vals[0] = v0;
    pol_in = p; ovr_in = o; und_in = u;
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk);
      digit_sel = 5'b1 << i;
      bcd = vals[i];
      repeat (3) @(negedge clk);
      strobe_n = 1'b0;
      repeat (lowc) @(negedge clk);
      strobe_n = 1'b1;
      repeat (4) @(negedge clk);
      if (flip && i == 4) pol_in = ~pol_in;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    vectors++;
    if ({tx_load, tx_par_even, overrun, run_hold, rx_clr} != 5'b0 || tx_data != 8'h00) begin
      fails++;
      $display("FAIL R1 reset: actual %b/%0h expected 00000/0",
               {tx_load, tx_par_even, overrun, run_hold, rx_clr}, tx_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    stream(4'd1, 4'd9, 4'd8, 4'd7, 4'd6, 1, 0, 0, 1, 12, 0);   // R3 R4 R5, short strobe
    stream(4'd0, 4'd2, 4'd0, 4'd5, 4'd3, 0, 1, 1, 6, 12, 0);   // R2 long strobe, R5 flags
    stream(4'd1, 4'd4, 4'd4, 4'd1, 4'd0, 1, 0, 1, 2, 12, 1);   // R6 polarity flip mid-stream
    stream(4'd0, 4'd3, 4'd6, 4'd9, 4'd2, 0, 0, 0, 2, 12, 1);   // R6 flip the other way
    tx_len = 40;
    stream(4'd1, 4'd5, 4'd6, 4'd7, 4'd8, 1, 1, 0, 1, 6, 0);    // R7 overrun on busy transmitter
    tx_len = 8;
    stream(4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 0, 0, 1, 1, 12, 0);   // R7 stays sticky
    // R8 and R9 command path
    @(negedge clk); rx_cmd = 1;
    repeat (2) @(negedge clk); rx_cmd = 0;
    repeat (2) @(negedge clk); adc_busy = 1;
    repeat (3) @(negedge clk); rx_cmd = 1;
    repeat (3) @(negedge clk); rx_cmd = 0; adc_busy = 0;
    repeat (2) @(negedge clk); adc_busy = 1; rx_cmd = 1;
    @(negedge clk); adc_busy = 0;
    @(negedge clk); adc_busy = 1; rx_cmd = 0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule